// File: doc/BRIEF.md
# Horizontal Polyphase Resampler with Colour Conversion and Write Masking

The block resizes one line of 8-bit YUV pixels horizontally. A line is first captured into an internal line store. The block then produces a programmable number of destination pixels, one per clock. Each destination pixel comes from a 5-tap polyphase filter. The filter's source position and phase come from a 16.16 fixed-point accumulator that advances by a programmable step, so the step sets the resize ratio. Coefficients are held per phase and per tap, and software loads them through a simple write port. To resize in both directions, the whole image is processed twice, with the data transposed between the two passes.

An optional fixed matrix can turn the filtered YUV result into RGB. Before each destination pixel leaves the block, one occlusion bit is fetched for its destination column. The pixel is emitted with its column number and a write enable equal to that bit. A masked pixel therefore still uses up a column number, so a downstream writer can skip pixels that other windows cover.

Top module: `hscale_csc_mask`

## Requirements
- R1: After reset, out_valid, out_we, mask_take and busy are low and in_ready is high. Every phase holds the identity kernel (256 on tap 2, 0 on the other taps), so a step of 0x0001_0000 reproduces the input line.
- R2: A pixel {Y[23:16],U[15:8],V[7:0]} is accepted when in_valid and in_ready are both high, and in_last marks the final pixel of the line. Only the first MAX_W pixels are stored and any extra pixels are dropped. After the line, cfg_out_w destination pixels are produced, one per clock, and in_ready stays low while busy is high.
- R3: The phase accumulator starts at 0 on each line and grows by cfg_step after every destination pixel. Its bits [31:16] give the source centre and bits [15:13] select one of 8 coefficient phases.
- R4: For each of Y, U and V separately, coefficient tap t (0..4) multiplies the stored pixel at centre+t-2.
- R5: A tap index below 0 reads pixel 0, and a tap index past the end of the line reads the last stored pixel.
- R6: Each filtered sum has 128 added, is shifted right arithmetically by 8 and is then clamped to 0..255.
- R7: When coef_wr is high, coef_val (signed 10-bit) is written to tap coef_tap of phase coef_ph. A write with coef_tap above 4 changes nothing.
- R8: With the conversion enabled, c=Y-16, d=U-128 and e=V-128. The outputs are R=(298c+409e+128)>>8, G=(298c-100d-208e+128)>>8 and B=(298c+516d+128)>>8, each clamped to 0..255 and emitted as {R,G,B}. With the conversion disabled, the filtered {Y,U,V} is emitted unchanged.
- R9: mask_take is high with mask_x set to the destination column in each producing cycle. mask_bit is sampled in that cycle. Two cycles later the pixel appears with out_valid high and out_we equal to that bit.
- R10: out_x counts 0..cfg_out_w-1 within a line, and masked pixels advance it too.
- R11: cfg_step, cfg_out_w and cfg_csc are captured with the last pixel of a line. Changes to them during the run have no effect on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_step | input | 32 | 16.16 source step per destination pixel |
| cfg_out_w | input | 16 | Destination pixels per line |
| cfg_csc | input | 1 | Enable YUV-to-RGB conversion |
| coef_wr | input | 1 | Coefficient write strobe |
| coef_ph | input | 3 | Coefficient phase |
| coef_tap | input | 3 | Coefficient tap |
| coef_val | input | 10 | Signed coefficient value |
| in_valid | input | 1 | Source pixel valid |
| in_last | input | 1 | Last source pixel of line |
| in_pix | input | 24 | Source pixel {Y,U,V} |
| in_ready | output | 1 | Source pixel may be accepted |
| mask_take | output | 1 | Occlusion bit requested this cycle |
| mask_x | output | 16 | Column of requested occlusion bit |
| mask_bit | input | 1 | Occlusion bit for mask_x |
| out_valid | output | 1 | Destination pixel valid |
| out_we | output | 1 | Destination pixel is to be written |
| out_x | output | 16 | Destination column |
| out_pix | output | 24 | Destination pixel, {Y,U,V} or {R,G,B} |
| busy | output | 1 | Producing destination pixels |

## Verification
The bench pushes the accumulator past both ends of short lines. A design that fails to replicate the edge pixels would read stale or neighbouring store entries there. Extreme kernels drive the sums above 255 and below 0, which exposes a clamp that wraps instead of saturating. All-zero and random masks check that out_we follows the bit of its own column while out_x keeps counting; an off-by-one in the mask timing shifts every enable by one column. Lines longer than the store, writes to a nonexistent tap, and configuration changed in the middle of a run each show whether that stimulus leaks into the output.

// File: rtl/hscale_pkg.sv
package hscale_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_RUN} hs_state_e;

    function automatic logic [7:0] rnd_clamp8(input logic signed [23:0] s);
        logic signed [23:0] r;
        r = (s + 24'sd128) >>> 8;
        if (r < 24'sd0)        return 8'd0;
        else if (r > 24'sd255) return 8'd255;
        else                   return r[7:0];
    endfunction
endpackage

// File: rtl/hscale_coef_bank.sv
module hscale_coef_bank #(
    parameter int PHASES = 8,
    parameter int TAPS   = 5,
    parameter int CW     = 10,
    parameter int FRAC   = 8,
    localparam int PHW   = $clog2(PHASES),
    localparam int TW    = $clog2(TAPS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [PHW-1:0]       wr_ph,
    input  logic [TW-1:0]        wr_tap,
    input  logic [CW-1:0]        wr_val,
    input  logic [PHW-1:0]       rd_ph,
    output logic [TAPS*CW-1:0]   rd_flat
);
    logic [CW-1:0] coef_d [PHASES][TAPS];
    logic [CW-1:0] coef_q [PHASES][TAPS];

    always_comb begin
        for (int p = 0; p < PHASES; p++) begin
            for (int t = 0; t < TAPS; t++) begin
                coef_d[p][t] = coef_q[p][t];
                if (wr && (int'(wr_ph) == p) && (int'(wr_tap) == t)) begin
                    coef_d[p][t] = wr_val;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < PHASES; p++) begin
            for (int t = 0; t < TAPS; t++) begin
                if (!rst_n) begin
                    coef_q[p][t] <= (t == TAPS / 2) ? CW'(1 << FRAC) : '0;
                end else begin
                    coef_q[p][t] <= coef_d[p][t];
                end
            end
        end
    end

    always_comb begin
        for (int t = 0; t < TAPS; t++) begin
            rd_flat[t*CW +: CW] = coef_q[rd_ph][t];
        end
    end
endmodule

// File: rtl/hscale_tap_mac.sv
module hscale_tap_mac #(
    parameter int TAPS = 5,
    parameter int CW   = 10,
    parameter int PW   = 8
) (
    input  logic [TAPS*PW-1:0] pix_flat,
    input  logic [TAPS*CW-1:0] coef_flat,
    output logic [PW-1:0]      res
);
    import hscale_pkg::*;
    logic signed [23:0] sum;
    logic signed [23:0] a;
    logic signed [23:0] b;

    always_comb begin
        sum = '0;
        a   = '0;
        b   = '0;
        for (int t = 0; t < TAPS; t++) begin
            a   = 24'($signed(coef_flat[t*CW +: CW]));
            b   = 24'($signed({1'b0, pix_flat[t*PW +: PW]}));
            sum = sum + a * b;
        end
        res = rnd_clamp8(sum);
    end
endmodule

// File: rtl/hscale_csc.sv
module hscale_csc (
    input  logic        en,
    input  logic [23:0] yuv,
    output logic [23:0] pix
);
    import hscale_pkg::*;
    logic signed [23:0] c, d, e;
    logic signed [23:0] r_s, g_s, b_s;

    always_comb begin
        c   = 24'($signed({1'b0, yuv[23:16]})) - 24'sd16;
        d   = 24'($signed({1'b0, yuv[15:8]}))  - 24'sd128;
        e   = 24'($signed({1'b0, yuv[7:0]}))   - 24'sd128;
        r_s = 24'sd298 * c + 24'sd409 * e;
        g_s = 24'sd298 * c - 24'sd100 * d - 24'sd208 * e;
        b_s = 24'sd298 * c + 24'sd516 * d;
        if (en) pix = {rnd_clamp8(r_s), rnd_clamp8(g_s), rnd_clamp8(b_s)};
        else    pix = yuv;
    end
endmodule

// File: rtl/hscale_csc_mask.sv
module hscale_csc_mask #(
    parameter int MAX_W  = 64,
    parameter int PHASES = 8,
    parameter int TAPS   = 5,
    parameter int CW     = 10,
    parameter int FRAC   = 8,
    parameter int XW     = 16,
    localparam int AW    = $clog2(MAX_W),
    localparam int NW    = $clog2(MAX_W + 1),
    localparam int PHW   = $clog2(PHASES),
    localparam int TW    = $clog2(TAPS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [31:0]   cfg_step,
    input  logic [XW-1:0] cfg_out_w,
    input  logic          cfg_csc,
    input  logic          coef_wr,
    input  logic [PHW-1:0] coef_ph,
    input  logic [TW-1:0] coef_tap,
    input  logic [CW-1:0] coef_val,
    input  logic          in_valid,
    input  logic          in_last,
    input  logic [23:0]   in_pix,
    output logic          in_ready,
    output logic          mask_take,
    output logic [XW-1:0] mask_x,
    input  logic          mask_bit,
    output logic          out_valid,
    output logic          out_we,
    output logic [XW-1:0] out_x,
    output logic [23:0]   out_pix,
    output logic          busy
);
    import hscale_pkg::*;

    typedef struct packed {
        hs_state_e     state;
        logic [NW-1:0] cnt;
        logic [NW-1:0] n;
        logic [31:0]   acc;
        logic [XW-1:0] x;
        logic [31:0]   step;
        logic [XW-1:0] ow;
        logic          csc;
        logic          s1_v;
        logic          s1_we;
        logic [XW-1:0] s1_x;
        logic [23:0]   s1_pix;
        logic          s1_csc;
        logic          o_v;
        logic          o_we;
        logic [XW-1:0] o_x;
        logic [23:0]   o_pix;
    } hs_regs_t;

    hs_regs_t st_d, st_q;
    logic [23:0] line_q [MAX_W];

    logic              run;
    logic              take_pix;
    logic              wr_line;
    logic [AW-1:0]     lim;
    logic [AW-1:0]     sel [TAPS];
    logic [TAPS*CW-1:0] coef_flat;
    logic [23:0]       filt;
    logic [23:0]       conv;

    assign run      = (st_q.state == ST_RUN);
    assign in_ready = !run;
    assign take_pix = in_valid && in_ready;
    assign wr_line  = take_pix && (st_q.cnt < NW'(MAX_W));
    assign lim      = AW'(st_q.n - NW'(1));

    hscale_coef_bank #(
        .PHASES(PHASES), .TAPS(TAPS), .CW(CW), .FRAC(FRAC)
    ) i_coef (
        .clk(clk), .rst_n(rst_n),
        .wr(coef_wr), .wr_ph(coef_ph), .wr_tap(coef_tap), .wr_val(coef_val),
        .rd_ph(st_q.acc[15 -: PHW]),
        .rd_flat(coef_flat)
    );

    // source index per tap with edge replication
    always_comb begin
        logic signed [18:0] raw;
        for (int t = 0; t < TAPS; t++) begin
            raw = $signed({3'b000, st_q.acc[31:16]}) + 19'(t) - 19'(TAPS / 2);
            if (raw < 19'sd0)                  sel[t] = '0;
            else if (raw > $signed(19'(lim)))  sel[t] = lim;
            else                               sel[t] = raw[AW-1:0];
        end
    end

    genvar gc;
    generate
        for (gc = 0; gc < 3; gc++) begin : g_comp
            logic [TAPS*8-1:0] pf;
            always_comb begin
                for (int t = 0; t < TAPS; t++) begin
                    pf[t*8 +: 8] = line_q[sel[t]][gc*8 +: 8];
                end
            end
            hscale_tap_mac #(.TAPS(TAPS), .CW(CW), .PW(8)) i_mac (
                .pix_flat(pf), .coef_flat(coef_flat), .res(filt[gc*8 +: 8])
            );
        end
    endgenerate

    hscale_csc i_csc (.en(st_q.s1_csc), .yuv(st_q.s1_pix), .pix(conv));

    always_comb begin
        st_d = st_q;
        if (st_q.state == ST_IDLE) begin
            if (wr_line) st_d.cnt = st_q.cnt + NW'(1);
            if (take_pix && in_last) begin
                st_d.n    = wr_line ? st_q.cnt + NW'(1) : st_q.cnt;
                st_d.cnt  = '0;
                st_d.step = cfg_step;
                st_d.ow   = cfg_out_w;
                st_d.csc  = cfg_csc;
                st_d.acc  = '0;
                st_d.x    = '0;
                st_d.state = (cfg_out_w != '0) ? ST_RUN : ST_IDLE;
            end
        end else begin
            st_d.acc = st_q.acc + st_q.step;
            st_d.x   = st_q.x + XW'(1);
            if (st_q.x == st_q.ow - XW'(1)) st_d.state = ST_IDLE;
        end
        st_d.s1_v   = run;
        st_d.s1_we  = run && mask_bit;
        st_d.s1_x   = st_q.x;
        st_d.s1_pix = filt;
        st_d.s1_csc = st_q.csc;
        st_d.o_v    = st_q.s1_v;
        st_d.o_we   = st_q.s1_v && st_q.s1_we;
        st_d.o_x    = st_q.s1_x;
        st_d.o_pix  = conv;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_line) line_q[st_q.cnt[AW-1:0]] <= in_pix;
    end

    assign mask_take = run;
    assign mask_x    = st_q.x;
    assign busy      = run;
    assign out_valid = st_q.o_v;
    assign out_we    = st_q.o_we;
    assign out_x     = st_q.o_x;
    assign out_pix   = st_q.o_pix;
endmodule

module hscale_csc_mask_chk #(
    parameter int XW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          busy,
    input logic          mask_take,
    input logic [XW-1:0] mask_x,
    input logic          mask_bit,
    input logic          out_valid,
    input logic          out_we,
    input logic [XW-1:0] out_x
);
    // R9
    we_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |-> out_valid);
    // R9
    mask_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mask_take, 2) |-> (out_valid && (out_we == $past(mask_bit, 2))));
    // R9
    take_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_take |-> busy);
    // R2
    no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_ready);
    // R10
    x_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid) && out_x != '0) |-> out_x == $past(out_x) + XW'(1));
    // R10
    x_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_take && !$past(busy)) |-> mask_x == '0);
endmodule

bind hscale_csc_mask hscale_csc_mask_chk #(.XW(XW)) i_hscale_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .busy(busy),
    .mask_take(mask_take), .mask_x(mask_x), .mask_bit(mask_bit),
    .out_valid(out_valid), .out_we(out_we), .out_x(out_x)
);

// File: tb/test_hscale_csc_mask.sv
`timescale 1ns/1ps
module test_hscale_csc_mask;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [31:0] cfg_step = 32'h0001_0000;
    logic [15:0] cfg_out_w = 16'd0;
    logic        cfg_csc = 0;
    logic        coef_wr = 0;
    logic [2:0]  coef_ph = 0;
    logic [2:0]  coef_tap = 0;
    logic [9:0]  coef_val = 0;
    logic        in_valid = 0, in_last = 0;
    logic [23:0] in_pix = 0;
    logic        in_ready, mask_take, mask_bit, out_valid, out_we, busy;
    logic [15:0] mask_x, out_x;
    logic [23:0] out_pix;
    logic [255:0] mask_pat = '1;

    int total = 0, bad = 0;
    int cm [8][5];
    logic [23:0] line_m [0:127];
    logic [23:0] exp_pix [0:255];
    logic        exp_we [0:255];
    int exp_n = 0, got = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;
    assign mask_bit = mask_pat[mask_x[7:0]];

    hscale_csc_mask i_hscale_csc_mask (
        .clk(clk), .rst_n(rst_n), .cfg_step(cfg_step), .cfg_out_w(cfg_out_w),
        .cfg_csc(cfg_csc), .coef_wr(coef_wr), .coef_ph(coef_ph), .coef_tap(coef_tap),
        .coef_val(coef_val), .in_valid(in_valid), .in_last(in_last), .in_pix(in_pix),
        .in_ready(in_ready), .mask_take(mask_take), .mask_x(mask_x), .mask_bit(mask_bit),
        .out_valid(out_valid), .out_we(out_we), .out_x(out_x), .out_pix(out_pix), .busy(busy)
    );

    function automatic int cl8(int s);
        int r = (s + 128) >>> 8;
        if (r < 0) return 0;
        if (r > 255) return 255;
        return r;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (got >= exp_n) begin
                check({cur_req, " extra output"}, 64'(out_x), 64'hFFFF);
            end else begin
                check({cur_req, " R10 x"}, 64'(out_x), 64'(got));
                check({cur_req, " R9 we"}, 64'(out_we), 64'(exp_we[got]));
                check(cur_req, 64'(out_pix), 64'(exp_pix[got]));
            end
            got++;
        end
    end

    task automatic wr_coef(int ph, int tap, int v);
        @(negedge clk);
        coef_wr = 1; coef_ph = 3'(ph); coef_tap = 3'(tap); coef_val = 10'(v);
        @(negedge clk);
        coef_wr = 0;
        if (tap < 5) cm[ph][tap] = v;
    endtask

    task automatic build_exp(int n, int ow, logic [31:0] step, bit csc);
        int nn = (n > 64) ? 64 : n;
        for (int x = 0; x < ow; x++) begin
            logic [31:0] acc = 32'(x) * step;
            int c = int'(acc[31:16]);
            int ph = int'(acc[15:13]);
            int comp [3];
            for (int k = 0; k < 3; k++) begin
                int s = 0;
                for (int t = 0; t < 5; t++) begin
                    int idx = c + t - 2;
                    if (idx < 0) idx = 0;
                    if (idx > nn - 1) idx = nn - 1;
                    s += cm[ph][t] * int'((line_m[idx] >> (16 - 8 * k)) & 24'hFF);
                end
                comp[k] = cl8(s);
            end
            if (csc) begin
                int cc = comp[0] - 16, d = comp[1] - 128, e = comp[2] - 128;
                exp_pix[x] = {8'(cl8(298*cc + 409*e)), 8'(cl8(298*cc - 100*d - 208*e)),
                              8'(cl8(298*cc + 516*d))};
            end else begin
                exp_pix[x] = {8'(comp[0]), 8'(comp[1]), 8'(comp[2])};
            end
            exp_we[x] = mask_pat[x % 256];
        end
    endtask

    task automatic run_line(string req, int n, int ow, logic [31:0] step, bit csc, bit scramble);
        int wd = 0;
        cur_req = req;
        for (int i = 0; i < n; i++) line_m[i] = 24'($urandom);
        build_exp(n, ow, step, csc);
        got = 0; exp_n = ow;
        @(negedge clk);
        cfg_step = step; cfg_out_w = 16'(ow); cfg_csc = csc;
        for (int i = 0; i < n; i++) begin
            in_valid = 1; in_pix = line_m[i]; in_last = (i == n - 1);
            @(negedge clk);
        end
        in_valid = 0; in_last = 0;
        if (scramble) begin
            cfg_step = 32'h0003_1234; cfg_out_w = 16'd3; cfg_csc = ~csc;
        end
        if (ow > 0) check({req, " R2 busy"}, {62'd0, busy, in_ready}, 64'b10);
        while (got < ow && wd < 3000) begin
            @(negedge clk); wd++;
        end
        if (wd >= 3000) check({req, " watchdog"}, 64'(got), 64'(ow));
        repeat (4) @(negedge clk);
        check({req, " count"}, 64'(got), 64'(ow));
    endtask

    initial begin
        for (int p = 0; p < 8; p++) for (int t = 0; t < 5; t++) cm[p][t] = (t == 2) ? 256 : 0;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {59'd0, out_valid, out_we, mask_take, busy, in_ready}, 64'd1);
        rst_n = 1;
        @(negedge clk);
        check("R1 idle", {59'd0, out_valid, out_we, mask_take, busy, in_ready}, 64'd1);
        // R1 identity kernel reproduces the line
        run_line("R1 identity", 16, 16, 32'h0001_0000, 0, 0);
        for (int i = 0; i < 16; i++) exp_pix[i] = line_m[i];
        // R7 tap above 4 ignored
        wr_coef(0, 5, 10'h1FF);
        wr_coef(0, 7, 10'h155);
        run_line("R7 bad tap ignored", 12, 12, 32'h0001_0000, 0, 0);
        // R7 R4 R3 random kernels, upscale
        for (int p = 0; p < 8; p++) for (int t = 0; t < 5; t++)
            wr_coef(p, t, $signed(10'($urandom_range(0, 200))) - 40);
        run_line("R3 R4 upscale", 20, 40, 32'h0000_8000, 0, 0);
        run_line("R3 downscale", 32, 16, 32'h0002_0000, 0, 0);
        run_line("R3 fraction step", 25, 30, 32'h0000_D555, 0, 0);
        // R5 edges
        run_line("R5 edge replicate", 8, 14, 32'h0001_0000, 0, 0);
        run_line("R5 single pixel", 1, 5, 32'h0000_4000, 0, 0);
        // R6 saturation high / low
        for (int p = 0; p < 8; p++) for (int t = 0; t < 5; t++) wr_coef(p, t, 511);
        run_line("R6 clamp high", 10, 10, 32'h0001_0000, 0, 0);
        for (int p = 0; p < 8; p++) for (int t = 0; t < 5; t++) wr_coef(p, t, (t == 2) ? -300 : 20);
        run_line("R6 clamp low", 10, 10, 32'h0001_0000, 0, 0);
        for (int p = 0; p < 8; p++) for (int t = 0; t < 5; t++)
            wr_coef(p, t, (t == 2) ? 160 : ((t == 1 || t == 3) ? 48 : 0));
        // R8 colour conversion
        run_line("R8 csc", 24, 24, 32'h0001_0000, 1, 0);
        // R9 R10 masks
        mask_pat = '0;
        run_line("R10 all masked", 16, 20, 32'h0000_C000, 0, 0);
        mask_pat = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        run_line("R9 random mask", 30, 40, 32'h0000_B000, 1, 0);
        // R2 overlong line
        mask_pat = '1;
        run_line("R2 overlong", 70, 70, 32'h0001_0000, 0, 0);
        // R11 config changed during run
        run_line("R11 cfg latched", 20, 25, 32'h0000_C000, 1, 1);
        // mixed random lines
        for (int k = 0; k < 6; k++) begin
            mask_pat = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            run_line("R4 random", int'($urandom_range(1, 64)), int'($urandom_range(1, 100)),
                     32'($urandom_range(32'h2000, 32'h3_0000)), 1'($urandom), 0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #900000;
        bad++; total++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule